// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit holds the vector length settings of a vector core. Software-visible settings go in through one write port: an 8-bit mask of enabled register banks, the count of integer registers used per element, the count of floating-point registers used per element, and the number of element slots in one bank. A configure strobe starts a recomputation of the largest vector length the banks can hold. The bank slots are shared among the registers an element uses, so the computation needs a division. A small multi-cycle restoring divider inside the unit does that division. While it works, `cfg_busy` is high. A one-cycle `cfg_done` pulse marks the new result.

A set-length request asks for a vector length. The unit grants the smaller of that request and the current maximum, and keeps the granted value as the current length. A request that meets an ongoing recomputation is held back and then served against the new maximum. The mask, the count of enabled banks, the maximum and the current length are always visible on read ports.

Top module: `vlen_cfg_unit`

## Requirements
- R1: A write with select 2'b00 stores only `wr_data[7:0]` as the bank mask. The bank count then equals the number of set bits in the stored mask. Select 2'b01 writes the integer usage count, 2'b10 writes the float usage count, and 2'b11 writes the bank size. Usage counts keep `wr_data[7:0]`, and the bank size keeps the full word.
- R2: On a configure, if integer usage plus float usage is below 2, the new maximum is the bank size times the bank count. Before any clamping, this is the product.
- R3: Otherwise the new maximum is floor(bank size / (integer usage + float usage - 1)) times the bank count.
- R4: The maximum is clamped to the ceiling `VL_CEIL`, which defaults to 2048.
- R5: A set-length request that arrives while the unit is idle raises `vl_grant_valid` for one cycle, on the cycle after the request. The granted length, `vl_grant_len`, is min(maximum, requested). The granted length also becomes `cur_len`.
- R6: After reset the read ports hold fixed values:
  - the mask is 0xFF
  - the bank count is 8
  - the maximum is 32
  - the current length is 0
  - the bank size is 256
  - both usage counts are 32, so an immediate configure gives 32 again
- R7: A set-length request made while the unit is busy, or in the same cycle as the configure strobe, is held. It is granted only after `cfg_done`, against the new maximum.
- R8: `cfg_busy` rises on the cycle after an accepted configure strobe and stays high until the cycle in which `cfg_done` is high. In that cycle it is already low. `cfg_done` lasts exactly one cycle.
- R9: Writes to the usage counts or the bank size while `cfg_busy` is high are ignored.
- R10: A configure strobe while `cfg_busy` is high is ignored. It produces no extra `cfg_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Setting select (mask, int usage, float usage, bank size) |
| wr_data | input | SIZE_W | Write data |
| cfg_start | input | 1 | Start recomputation of the maximum |
| cfg_busy | output | 1 | Recomputation in progress |
| cfg_done | output | 1 | One-cycle pulse: new maximum valid |
| vl_req_valid | input | 1 | Set-length request strobe |
| vl_req_len | input | LEN_W | Requested length |
| vl_grant_valid | output | 1 | One-cycle grant pulse |
| vl_grant_len | output | LEN_W | Granted length |
| bank_mask | output | MASK_W | Current bank mask |
| bank_count | output | CB_W | Number of enabled banks |
| max_len | output | LEN_W | Current maximum vector length |
| cur_len | output | LEN_W | Current vector length |

## Verification
The bench drives each branch of the maximum formula and the ceiling clamp:
- Using an unclamped product where the ceiling applies, or applying the ceiling to the quotient, gives a visibly wrong maximum.
- A non-exact division such as 100/7 exposes an off-by-one divisor or a rounding quotient.
- An empty mask must give a zero maximum.

The remaining cases probe the busy window:
- A request issued together with the configure strobe must come back with the new maximum. A design that grants at once returns a length bounded by the stale maximum.
- Usage and size writes made while busy must leave the next result unchanged.
- A second strobe made while busy must not create a second done pulse.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  typedef enum logic [1:0] {
    SEL_MASK = 2'b00,
    SEL_INT  = 2'b01,
    SEL_FLT  = 2'b10,
    SEL_SIZE = 2'b11
  } vlc_sel_e;

  function automatic int vlc_ones(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/vlc_popcount.sv
module vlc_popcount #(
  parameter int W = 8,
  localparam int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [OW-1:0] ones
);
  // adder chain; each stage adds one mask bit
  logic [OW-1:0] part [W+1];
  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_stage
    assign part[g+1] = part[g] + OW'(vec[g]);
  end
  assign ones = part[W];
endmodule

// File: rtl/vlc_divider.sv
module vlc_divider #(
  parameter int N_W = 16,
  parameter int D_W = 9,
  localparam int C_W = $clog2(N_W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [N_W-1:0] quotient
);
  logic [N_W-1:0] num_q;
  logic [D_W-1:0] dvr_q;
  logic [D_W-1:0] rem_q;
  logic [C_W-1:0] cnt_q;
  logic [D_W:0]   trial;
  logic           fits;
  logic [D_W:0]   diff;

  always_comb begin
    trial = {rem_q, num_q[N_W-1]};
    fits  = trial >= {1'b0, dvr_q};
    diff  = trial - {1'b0, dvr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      num_q    <= '0;
      dvr_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        num_q    <= dividend;
        dvr_q    <= divisor;
        rem_q    <= '0;
        quotient <= '0;
        cnt_q    <= C_W'(N_W);
      end else if (busy) begin
        rem_q    <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        quotient <= {quotient[N_W-2:0], fits};
        num_q    <= num_q << 1;
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == C_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: divider finishes with a single pulse
  a_r3_div_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_div_end_signals_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/vlc_scale_clamp.sv
module vlc_scale_clamp #(
  parameter int Q_W     = 16,
  parameter int CB_W    = 4,
  parameter int LEN_W   = 16,
  parameter int VL_CEIL = 2048,
  localparam int P_W    = Q_W + CB_W
) (
  input  logic [Q_W-1:0]   quot,
  input  logic [CB_W-1:0]  banks,
  output logic [LEN_W-1:0] len
);
  logic [P_W-1:0] prod;
  always_comb begin
    prod = P_W'(quot) * P_W'(banks);
    if (prod > P_W'(VL_CEIL)) len = LEN_W'(VL_CEIL);
    else                      len = prod[LEN_W-1:0];
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit #(
  parameter int MASK_W     = 8,
  parameter int CNT_W      = 8,
  parameter int SIZE_W     = 16,
  parameter int LEN_W      = 16,
  parameter int VL_CEIL    = 2048,
  parameter int RESET_MASK = 255,
  parameter int RESET_USE  = 32,
  parameter int RESET_SIZE = 256,
  parameter int RESET_MAX  = 32,
  localparam int CB_W      = $clog2(MASK_W + 1),
  localparam int D_W       = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SIZE_W-1:0] wr_data,
  input  logic              cfg_start,
  output logic              cfg_busy,
  output logic              cfg_done,
  input  logic              vl_req_valid,
  input  logic [LEN_W-1:0]  vl_req_len,
  output logic              vl_grant_valid,
  output logic [LEN_W-1:0]  vl_grant_len,
  output logic [MASK_W-1:0] bank_mask,
  output logic [CB_W-1:0]   bank_count,
  output logic [LEN_W-1:0]  max_len,
  output logic [LEN_W-1:0]  cur_len
);
  import vlc_pkg::*;

  localparam int RESET_CNT = vlc_ones(32'(RESET_MASK));

  logic [CNT_W-1:0]  int_use, flt_use;
  logic [SIZE_W-1:0] bank_size;
  logic [CB_W-1:0]   cnt_snap;
  logic [CB_W-1:0]   wr_ones;
  logic [D_W-1:0]    use_sum, div_dvr;
  logic              div_busy, div_done;
  logic [SIZE_W-1:0] div_quot;
  logic [LEN_W-1:0]  new_max;
  logic              accept_cfg;
  logic              req_pend;
  logic [LEN_W-1:0]  req_hold;
  vlc_sel_e          sel;

  assign sel        = vlc_sel_e'(wr_sel);
  assign accept_cfg = cfg_start && !cfg_busy;
  assign use_sum    = D_W'(int_use) + D_W'(flt_use);
  assign div_dvr    = (use_sum < D_W'(2)) ? D_W'(1) : use_sum - D_W'(1);

  vlc_popcount #(.W(MASK_W)) u_pop (
    .vec  (wr_data[MASK_W-1:0]),
    .ones (wr_ones)
  );

  vlc_divider #(.N_W(SIZE_W), .D_W(D_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (accept_cfg),
    .dividend (bank_size),
    .divisor  (div_dvr),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quot)
  );

  vlc_scale_clamp #(
    .Q_W(SIZE_W), .CB_W(CB_W), .LEN_W(LEN_W), .VL_CEIL(VL_CEIL)
  ) u_scale (
    .quot  (div_quot),
    .banks (cnt_snap),
    .len   (new_max)
  );

  // setting registers
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_mask  <= MASK_W'(RESET_MASK);
      bank_count <= CB_W'(RESET_CNT);
      int_use    <= CNT_W'(RESET_USE);
      flt_use    <= CNT_W'(RESET_USE);
      bank_size  <= SIZE_W'(RESET_SIZE);
    end else if (wr_en) begin
      case (sel)
        SEL_MASK: begin
          bank_mask  <= wr_data[MASK_W-1:0];
          bank_count <= wr_ones;
        end
        SEL_INT:  if (!cfg_busy) int_use   <= wr_data[CNT_W-1:0];
        SEL_FLT:  if (!cfg_busy) flt_use   <= wr_data[CNT_W-1:0];
        SEL_SIZE: if (!cfg_busy) bank_size <= wr_data;
        default: ;
      endcase
    end
  end

  // configure sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_busy <= 1'b0;
      cfg_done <= 1'b0;
      cnt_snap <= '0;
      max_len  <= LEN_W'(RESET_MAX);
    end else begin
      cfg_done <= 1'b0;
      if (accept_cfg) begin
        cfg_busy <= 1'b1;
        cnt_snap <= bank_count;
      end
      if (div_done) begin
        max_len  <= new_max;
        cfg_done <= 1'b1;
        cfg_busy <= 1'b0;
      end
    end
  end

  // set-length requests, held across a recomputation
  always_ff @(posedge clk) begin
    if (rst) begin
      req_pend       <= 1'b0;
      req_hold       <= '0;
      vl_grant_valid <= 1'b0;
      vl_grant_len   <= '0;
      cur_len        <= '0;
    end else begin
      vl_grant_valid <= 1'b0;
      if (vl_req_valid && (cfg_busy || cfg_start)) begin
        req_pend <= 1'b1;
        req_hold <= vl_req_len;
      end else if (vl_req_valid) begin
        req_pend       <= 1'b0;
        vl_grant_valid <= 1'b1;
        vl_grant_len   <= (vl_req_len < max_len) ? vl_req_len : max_len;
        cur_len        <= (vl_req_len < max_len) ? vl_req_len : max_len;
      end else if (req_pend && !cfg_busy) begin
        req_pend       <= 1'b0;
        vl_grant_valid <= 1'b1;
        vl_grant_len   <= (req_hold < max_len) ? req_hold : max_len;
        cur_len        <= (req_hold < max_len) ? req_hold : max_len;
      end
    end
  end

  a_r1_count_matches_mask: assert property (@(posedge clk) disable iff (rst)
    bank_count == CB_W'($countones(bank_mask)));
  a_r4_max_capped: assert property (@(posedge clk) disable iff (rst)
    max_len <= LEN_W'(VL_CEIL));
  a_r5_grant_bounded: assert property (@(posedge clk) disable iff (rst)
    vl_grant_valid |-> (vl_grant_len <= max_len && vl_grant_len == cur_len));
  a_r7_no_grant_after_busy: assert property (@(posedge clk) disable iff (rst)
    vl_grant_valid |-> !$past(cfg_busy));
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> !cfg_done);
  a_r8_busy_ends_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_busy) |-> cfg_done);
  a_r9_settings_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_busy) |-> ($stable(int_use) && $stable(flt_use) && $stable(bank_size)));
  a_r10_busy_matches_divider: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |-> (div_busy || div_done));
endmodule

// File: tb/test_vlen_cfg_unit.sv
module test_vlen_cfg_unit;
  localparam int LEN_W = 16;
  localparam int CEIL  = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'b00;
  logic [15:0] wr_data = '0;
  logic        cfg_start = 1'b0;
  logic        cfg_busy, cfg_done;
  logic        vl_req_valid = 1'b0;
  logic [15:0] vl_req_len = '0;
  logic        vl_grant_valid;
  logic [15:0] vl_grant_len;
  logic [7:0]  bank_mask;
  logic [3:0]  bank_count;
  logic [15:0] max_len, cur_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // bench copy of the settings
  int m_mask = 255, m_int = 32, m_flt = 32, m_size = 256;

  always #2 clk = ~clk;

  vlen_cfg_unit i_vlen_cfg_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_start(cfg_start), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
    .vl_req_valid(vl_req_valid), .vl_req_len(vl_req_len),
    .vl_grant_valid(vl_grant_valid), .vl_grant_len(vl_grant_len),
    .bank_mask(bank_mask), .bank_count(bank_count),
    .max_len(max_len), .cur_len(cur_len)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_max(input int mask, input int size, input int iu, input int fu);
    int q, p;
    q = (iu + fu < 2) ? size : size / (iu + fu - 1);
    p = q * $countones(mask[7:0]);
    return (p > CEIL) ? CEIL : p;
  endfunction

  task automatic write_reg(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input int mask, input int size, input int iu, input int fu);
    write_reg(2'b00, mask); write_reg(2'b11, size);
    write_reg(2'b01, iu);   write_reg(2'b10, fu);
    m_mask = mask & 255; m_size = size; m_int = iu & 255; m_flt = fu & 255;
  endtask

  // waits for done; returns pulse count and whether busy held until done
  task automatic wait_done(output int dones, output bit busy_ok);
    bit seen;
    dones = 0; busy_ok = 1'b1; seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cfg_done) begin
        dones++;
        seen = 1'b1;
        if (cfg_busy) busy_ok = 1'b0;
      end else if (!seen && !cfg_busy) busy_ok = 1'b0;
      else if (seen && cfg_busy) busy_ok = 1'b0;
    end
  endtask

  task automatic configure(input string req);
    int d; bit ok;
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    wait_done(d, ok);
    check(req, max_len, exp_max(m_mask, m_size, m_int, m_flt));
  endtask

  task automatic t_reset();
    check("R6 mask", bank_mask, 255);
    check("R6 count", bank_count, 8);
    check("R6 max", max_len, 32);
    check("R6 cur", cur_len, 0);
    configure("R6 reset settings give 32");
  endtask

  task automatic t_mask_write();
    write_reg(2'b00, 16'h3A5);
    check("R1 mask low bits", bank_mask, 8'hA5);
    check("R1 bank count", bank_count, 4);
    m_mask = 8'hA5;
  endtask

  task automatic t_small_sum();
    set_all(8'hA5, 256, 1, 0);
    configure("R2 sum one");
    check("R2 value", max_len, 1024);
    set_all(8'h0F, 300, 0, 0);
    configure("R2 sum zero");
    check("R2 value zero", max_len, 1200);
  endtask

  task automatic t_divide();
    set_all(8'hA5, 256, 3, 2);
    configure("R3 even division");
    check("R3 256/4*4", max_len, 256);
    set_all(8'hA5, 100, 5, 3);
    configure("R3 floor division");
    check("R3 100/7*4", max_len, 56);
    set_all(8'h00, 500, 2, 2);
    configure("R3 empty mask");
    check("R3 zero banks", max_len, 0);
  endtask

  task automatic t_clamp();
    set_all(8'hFF, 1000, 1, 1);
    configure("R4 clamp");
    check("R4 ceiling", max_len, CEIL);
  endtask

  task automatic setvl(input int req_len, input string req);
    int e;
    e = (req_len < max_len) ? req_len : max_len;
    @(negedge clk); vl_req_valid = 1'b1; vl_req_len = 16'(req_len);
    @(negedge clk); vl_req_valid = 1'b0;
    check({req, " grant valid"}, vl_grant_valid, 1);
    check({req, " grant len"}, vl_grant_len, e);
    check({req, " cur len"}, cur_len, e);
    @(negedge clk);
    check({req, " grant one cycle"}, vl_grant_valid, 0);
  endtask

  task automatic t_setvl();
    setvl(5000, "R5 above max");
    setvl(17, "R5 below max");
  endtask

  task automatic t_stall();
    bit seen_done, granted;
    int glen;
    set_all(8'h03, 256, 2, 1);
    @(negedge clk);
    cfg_start = 1'b1; vl_req_valid = 1'b1; vl_req_len = 16'd500;
    @(negedge clk);
    cfg_start = 1'b0; vl_req_valid = 1'b0;
    seen_done = 1'b0; granted = 1'b0; glen = -1;
    for (int i = 0; i < 60; i++) begin
      if (vl_grant_valid && !granted) begin
        granted = 1'b1; glen = vl_grant_len;
        check("R7 grant after done", seen_done, 1);
      end
      if (cfg_done) seen_done = 1'b1;
      @(negedge clk);
    end
    check("R7 granted", granted, 1);
    check("R7 uses new max", glen, 256);
    check("R7 cur len", cur_len, 256);
  endtask

  task automatic t_busy_writes();
    int d; bit ok;
    set_all(8'hFF, 256, 3, 2);
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    check("R8 busy after start", cfg_busy, 1);
    wr_en = 1'b1; wr_sel = 2'b01; wr_data = 16'd0;
    @(negedge clk); wr_sel = 2'b11; wr_data = 16'd50;
    @(negedge clk); wr_en = 1'b0;
    cfg_start = 1'b1;
    @(negedge clk); cfg_start = 1'b0;
    wait_done(d, ok);
    check("R8 single done pulse", d, 1);
    check("R8 busy window", ok, 1);
    check("R10 no second done", d, 1);
    check("R9 result uses old settings", max_len, 512);
    configure("R9 writes dropped");
    check("R9 still 512", max_len, 512);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_write();
    t_small_sum();
    t_divide();
    t_clamp();
    t_setvl();
    t_stall();
    t_busy_writes();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule